// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary up-counter, four bits wide by default, that wraps from its all-ones value back to zero. On a rising clock edge it can take a parallel value from its data inputs, or step by one, or hold. Two count enables gate the stepping. The first is a parallel enable that is shared by every stage. The second is a trickle enable that is passed from stage to stage. A terminal-count flag lets several copies be chained into a wider counter that stays fully synchronous.

A build-time parameter sets how the active-low clear behaves. In one variant the clear is asynchronous: it forces the count to zero at once and overrides every other input, the clock included. In the other variant the clear is synchronous: it zeroes the count on the next rising edge and wins over both loading and counting.

To build a wide counter, tie each stage's trickle enable to the previous stage's terminal count. The parallel enable and the load enable go to every stage in common.

Top module: `sync_preset_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, while clr_n is low the output q is 0 without waiting for a clock edge, and clock edges during that time do not change it.
- R2: With ASYNC_CLEAR=0, a rising edge with clr_n low sets q to 0, whatever the values of load_n, en_p and en_t. Before that edge, q keeps its value.
- R3: A rising edge with clr_n high and load_n low copies din into q, whatever the levels of en_p and en_t.
- R4: A rising edge with clr_n high, load_n high, en_p high and en_t high adds one to q, modulo 2**WIDTH, so all ones goes to zero.
- R5: A rising edge with clr_n high, load_n high and either en_p or en_t low leaves q unchanged.
- R6: tc is 1 exactly when q is all ones and en_t is 1. It does not depend on en_p.
- R7: When stages are chained, with stage 0 taking en_t from outside and each later stage taking en_t from the previous stage's tc, the stages behave as a single counter of the combined width. This covers counting, loading, wrapping and clearing, and the last stage's tc is high when the combined count is all ones and the outside en_t is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes except the asynchronous clear occur on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous, depending on ASYNC_CLEAR |
| load_n | input | 1 | Active-low parallel-load enable |
| din | input | WIDTH | Parallel load value |
| en_p | input | 1 | Active-high parallel count enable |
| en_t | input | 1 | Active-high trickle count enable; also gates tc |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: q all ones while en_t is high |

## Verification
The bench chains three stages into a 12-bit counter in each clear variant and compares both chains with a behavioural model on every clock. A load just below a nibble boundary, followed by counting, shows whether the carry moves through the trickle chain in the same edge. A load just below the full 12-bit limit shows whether the whole counter wraps and whether the final terminal count is correct. Dropping the parallel enable while the count sits at all ones separates the two enables in how they act on the terminal count. Loads with the enables low, and a clear that coincides with a load, test the priority order. A clear asserted in the middle of a cycle shows the asynchronous chain zeroing at once while the synchronous chain waits for the edge. A long biased random run then mixes all of these.

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  wire              step = en_p & en_t;

  always_comb begin
    if (!load_n)   cnt_d = din;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  generate
    if (ASYNC_CLEAR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      a_r1_async_clear: assert property (@(posedge clk) !clr_n |-> q == '0);
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        cnt_q <= clr_n ? cnt_d : '0;
      end

      a_r2_sync_clear: assert property (@(posedge clk) !clr_n |=> q == '0);
    end
  endgenerate

  assign q  = cnt_q;
  assign tc = en_t & (cnt_q == ALL_ONES);

  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));
  a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && en_p && en_t |=> q == $past(q) + 1'b1);
  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(en_p && en_t) |=> $stable(q));
  a_r6_tc_ignores_p: assert property (@(posedge clk) disable iff (!clr_n)
    !$stable(en_p) && $stable(en_t) && $stable(q) |-> $stable(tc));
endmodule

// File: tb/sync_preset_counter_bench.sv
`timescale 1ns/1ps
module sync_preset_counter_bench;
  localparam int W = 4;
  localparam int N = 3;
  localparam int TOP = (1 << (W*N)) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic clr_n = 1'b1, load_n = 1'b1, cep = 1'b0, cet = 1'b0;
  logic [W*N-1:0] din = '0;

  logic [W*N-1:0] qs, qa;
  logic [N:0] ts, ta;
  assign ts[0] = cet;
  assign ta[0] = cet;

  for (genvar i = 0; i < N; i++) begin : g_sync
    sync_preset_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) u_sync_preset_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[i*W +: W]),
      .en_p(cep), .en_t(ts[i]), .q(qs[i*W +: W]), .tc(ts[i+1]));
  end
  for (genvar i = 0; i < N; i++) begin : g_async
    sync_preset_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) u_sync_preset_counter (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[i*W +: W]),
      .en_p(cep), .en_t(ta[i]), .q(qa[i*W +: W]), .tc(ta[i+1]));
  end

  int checks = 0, errors = 0;
  int ms = 0, ma = 0;
  string tag_s = "R2", tag_a = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int m, output string tag);
    if (!load_n)         begin tag = "R3"; return int'(din); end
    else if (cep && cet) begin tag = "R4"; return (m + 1) & TOP; end
    else                 begin tag = "R5"; return m; end
  endfunction

  task automatic compare();
    chk({tag_s, " R7 sync chain q"}, int'(qs), ms);
    chk({tag_a, " R7 async chain q"}, int'(qa), ma);
    chk("R6 R7 sync tc", int'(ts[N]), int'(ms == TOP && cet));
    chk("R6 R7 async tc", int'(ta[N]), int'(ma == TOP && cet));
    chk("R6 stage0 tc", int'(g_sync[0].u_sync_preset_counter.tc),
        int'((ms & 15) == 15 && cet));
  endtask

  task automatic step();
    @(posedge clk);
    if (!clr_n) begin ms = 0; tag_s = "R2"; end
    else ms = nxt(ms, tag_s);
    if (!clr_n) begin ma = 0; tag_a = "R1"; end
    else ma = nxt(ma, tag_a);
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input bit c, input bit l, input bit p, input bit t, input int d);
    clr_n = c; load_n = l; cep = p; cet = t; din = d[W*N-1:0];
  endtask

  bit done = 1'b0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 clr_n = 1'b0;
    #1 chk("R1 async clear before edge", int'(qa), 0);
    step(); step();
    drive(1, 0, 0, 0, 12'h0F0); step();
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 40; i++) step();
    drive(1, 0, 0, 1, 12'hFFA); step();
    drive(1, 1, 1, 1, 0);
    for (int i = 0; i < 12; i++) step();
    drive(1, 0, 0, 0, 12'hFFF); step();
    drive(1, 1, 0, 1, 0); step();
    drive(1, 1, 1, 0, 0); step();
    drive(1, 1, 0, 0, 0); step();
    drive(1, 0, 1, 1, 12'h5A3); step();
    drive(0, 0, 1, 1, 12'h777); step();
    drive(1, 1, 1, 1, 0); step(); step(); step();
    #1 clr_n = 1'b0;
    ma = 0;
    #1 chk("R1 async clears mid cycle", int'(qa), 0);
    chk("R2 sync waits for edge", int'(qs), ms);
    tag_a = "R1";
    step();
    drive(0, 1, 1, 1, 0); step(); step();
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 50) != 0, ($urandom % 25) != 0, ($urandom % 8) != 0,
            ($urandom % 8) != 0, int'($urandom));
      step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule